// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns parallel characters into asynchronous serial frames on a single output line. A character is written into a one-entry holding register. At the next bit-rate tick with the shift register free, the character is moved into the shift register together with its framing. The frame starts with a low start bit. The data bits follow, least significant first, then an optional ninth bit, an optional parity bit, and one or two high stop bits. The line format is taken from static control inputs and fixed for each frame at the moment it is loaded.

The surrounding logic supplies one single-cycle tick per bit period and polls or takes interrupts from two flags. One flag shows that the holding register can accept a character. The other shows that the last frame has left the line and nothing is waiting. Parity can be even, odd or stuck at a fixed level. A break control holds the line low. Dropping the enable stops the transmitter only after the character being shifted and any character waiting in the holding register have both gone out.

Top module: `sertx_top`

## Requirements
- R1: During and right after reset, `tx_o` is 1, `hold_empty` is 1 and `tx_done` is 0.
- R2: Each frame begins with one low start bit, followed by the data bits least significant first. The number of data bits is 5, 6, 7 or 8 for `word_len` = 0, 1, 2 or 3. Data bits above that count are ignored. Each bit lasts one tick period.
- R3: With `ninth_en` = 1, `wr_data[8]` is sent directly after the last data bit.
- R4: With `par_en` = 1, a parity bit follows the last data bit (the ninth bit included) and comes before the first stop bit. With `par_even` = 1 it is the XOR of the sent data bits, and with `par_even` = 0 it is the inverse of that XOR. With `par_en` = 0 no parity bit is sent.
- R5: With `par_en` and `par_stick` both 1, the parity bit is 0 when `par_even` = 1 and 1 when `par_even` = 0.
- R6: The frame ends with one high stop bit, or two when `two_stop` = 1.
- R7: While `brk` is 1, `tx_o` is 0. When `brk` returns to 0, the normal line level is restored.
- R8: A write made while `hold_empty` is 0 is ignored. The held character is kept and sent once.
- R9: The held character moves to the shift register on a tick at which the shift register is empty or sends its last bit, provided the transmitter is enabled. Consecutive frames therefore follow with no idle bit between them.
- R10: `tx_done` sets when a frame's last stop bit ends and no character is waiting. It stays set until `done_clr` is pulsed, which covers both clearing by software and acknowledging the interrupt.
- R11: After `tx_enable` drops, the frame in progress and a character already waiting are still sent. Characters written after that stay held, and the line stays idle, until `tx_enable` returns to 1.
- R12: `irq_hold` equals `ie_hold` AND `hold_empty`, and `irq_done` equals `ie_done` AND `tx_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 9 | Character; bit 8 is the ninth bit |
| tx_enable | input | 1 | Transmitter enable; a drop takes effect once pending data is out |
| word_len | input | 2 | Data bit count code: 0..3 selects 5..8 bits |
| ninth_en | input | 1 | Send `wr_data[8]` after the data bits |
| two_stop | input | 1 | Two stop bits instead of one |
| par_en | input | 1 | Insert a parity bit |
| par_even | input | 1 | 1 = even parity, 0 = odd parity |
| par_stick | input | 1 | Parity bit stuck at the inverse of `par_even` |
| brk | input | 1 | Force the line low |
| done_clr | input | 1 | Clear `tx_done` (write-one or interrupt acknowledge) |
| ie_hold | input | 1 | Interrupt enable for holding-register empty |
| ie_done | input | 1 | Interrupt enable for transmission complete |
| tx_o | output | 1 | Serial line, idle high |
| hold_empty | output | 1 | Holding register can accept a write |
| tx_done | output | 1 | Transmission complete flag |
| irq_hold | output | 1 | Holding-register-empty interrupt request |
| irq_done | output | 1 | Transmission-complete interrupt request |

## Verification
Characters are sent under each word-length code, using values whose bits above the selected length are set. A wrong length or a wrong bit order then shows up as a frame mismatch. Normal parity uses one data value under both even and odd select, so an inverted sense is exposed. The all-zero value separates the XOR from its inverse, and the stick modes check that the parity bit no longer follows the data. Ninth-bit and two-stop frames check where the ninth bit, the parity bit and the stop bits fall. Pairs of writes in close succession tell apart a gapless hand-over, an ignored write to a full holding register, and the drain-then-stop behaviour of a late disable.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int MAX_DATA = 8;
  localparam int WR_W     = MAX_DATA + 1;
  localparam int FRAME_W  = MAX_DATA + 5;
  localparam int CNT_W    = $clog2(FRAME_W + 1);

  typedef struct packed {
    logic [1:0] wlen;
    logic       ninth;
    logic       two_stop;
    logic       par_en;
    logic       par_even;
    logic       par_stick;
  } line_cfg_t;

  typedef struct packed {
    logic [FRAME_W-1:0] bits;
    logic [CNT_W-1:0]   len;
  } frame_t;

  function automatic logic [3:0] data_bits(input logic [1:0] code);
    return 4'd5 + {2'b00, code};
  endfunction

  function automatic logic par_bit(input logic [WR_W-1:0] d, input line_cfg_t c);
    logic x;
    x = 1'b0;
    for (int i = 0; i < MAX_DATA; i++)
      if (i < int'(data_bits(c.wlen))) x ^= d[i];
    if (c.ninth) x ^= d[MAX_DATA];
    if (c.par_stick) return ~c.par_even;
    return c.par_even ? x : ~x;
  endfunction

  function automatic frame_t build_frame(input logic [WR_W-1:0] d, input line_cfg_t c);
    frame_t f;
    logic [FRAME_W-1:0] b;
    int pos;
    b = '1;
    b[0] = 1'b0;
    pos = 1;
    for (int i = 0; i < MAX_DATA; i++)
      if (i < int'(data_bits(c.wlen))) begin
        b[pos] = d[i];
        pos++;
      end
    if (c.ninth) begin
      b[pos] = d[MAX_DATA];
      pos++;
    end
    if (c.par_en) begin
      b[pos] = par_bit(d, c);
      pos++;
    end
    pos += c.two_stop ? 2 : 1;
    f.bits = b;
    f.len  = CNT_W'(pos);
    return f;
  endfunction
endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          take,
  output logic          full,
  output logic [DW-1:0] data
);
  logic          full_q;
  logic [DW-1:0] data_q;
  logic          wr_accept;

  assign wr_accept = wr_en && !full_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (take) full_q <= 1'b0;
      if (wr_accept) begin
        data_q <= wr_data;
        full_q <= 1'b1;
      end
    end
  end

  assign full = full_q;
  assign data = data_q;

  // R8
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !take) |=> (full_q && $stable(data_q)));

  // R9
  take_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> full_q);
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
  import sertx_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick,
  input  logic   load,
  input  frame_t frame_in,
  output logic   busy,
  output logic   line,
  output logic   frame_end
);
  logic [FRAME_W-1:0] sreg;
  logic [CNT_W-1:0]   cnt;
  logic               busy_q;

  assign frame_end = busy_q && tick && (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg   <= '1;
      cnt    <= '0;
      busy_q <= 1'b0;
    end else if (load) begin
      sreg   <= frame_in.bits;
      cnt    <= frame_in.len;
      busy_q <= 1'b1;
    end else if (busy_q && tick) begin
      sreg <= {1'b1, sreg[FRAME_W-1:1]};
      cnt  <= cnt - CNT_W'(1);
      if (cnt == CNT_W'(1)) busy_q <= 1'b0;
    end
  end

  assign busy = busy_q;
  assign line = busy_q ? sreg[0] : 1'b1;

  // R9
  load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy_q);

  // R2
  frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt != '0 && int'(cnt) <= FRAME_W));

  // R6
  stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> line);
endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            baud_tick,
  input  logic            wr_en,
  input  logic [WR_W-1:0] wr_data,
  input  logic            tx_enable,
  input  logic [1:0]      word_len,
  input  logic            ninth_en,
  input  logic            two_stop,
  input  logic            par_en,
  input  logic            par_even,
  input  logic            par_stick,
  input  logic            brk,
  input  logic            done_clr,
  input  logic            ie_hold,
  input  logic            ie_done,
  output logic            tx_o,
  output logic            hold_empty,
  output logic            tx_done,
  output logic            irq_hold,
  output logic            irq_done
);
  line_cfg_t       cfg;
  frame_t          frame_nx;
  logic            hold_full;
  logic [WR_W-1:0] hold_data;
  logic            busy;
  logic            line;
  logic            frame_end;
  logic            take;
  logic            en_q;
  logic            done_q;

  assign cfg = '{wlen: word_len, ninth: ninth_en, two_stop: two_stop,
                 par_en: par_en, par_even: par_even, par_stick: par_stick};

  assign frame_nx = build_frame(hold_data, cfg);
  assign take     = baud_tick && en_q && hold_full && (!busy || frame_end);

  sertx_hold #(.DW(WR_W)) hold_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .take    (take),
    .full    (hold_full),
    .data    (hold_data)
  );

  sertx_shift shift_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (baud_tick),
    .load      (take),
    .frame_in  (frame_nx),
    .busy      (busy),
    .line      (line),
    .frame_end (frame_end)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      en_q <= tx_enable || (en_q && (busy || hold_full));
      if (frame_end && !take) done_q <= 1'b1;
      else if (done_clr)      done_q <= 1'b0;
    end
  end

  assign tx_o       = brk ? 1'b0 : line;
  assign hold_empty = !hold_full;
  assign tx_done    = done_q;
  assign irq_hold   = ie_hold && hold_empty;
  assign irq_done   = ie_done && done_q;

  // R10
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(frame_end));

  // R11
  en_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_q) |-> $past(!busy && !hold_full));

  // R2
  start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !brk) |=> !tx_o);
endmodule

// File: tb/sertx_top_tb_top.sv
`timescale 1ns/1ps
module sertx_top_tb_top;
  localparam int DIV = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic baud_tick = 1'b0;
  logic wr_en = 1'b0;
  logic [8:0] wr_data = '0;
  logic tx_enable = 1'b0;
  logic [1:0] word_len = 2'd3;
  logic ninth_en = 1'b0, two_stop = 1'b0, par_en = 1'b0, par_even = 1'b0;
  logic par_stick = 1'b0, brk = 1'b0, done_clr = 1'b0, ie_hold = 1'b0, ie_done = 1'b0;
  logic tx_o, hold_empty, tx_done, irq_hold, irq_done;

  sertx_top dut_i (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en), .wr_data(wr_data),
    .tx_enable(tx_enable), .word_len(word_len), .ninth_en(ninth_en), .two_stop(two_stop),
    .par_en(par_en), .par_even(par_even), .par_stick(par_stick), .brk(brk),
    .done_clr(done_clr), .ie_hold(ie_hold), .ie_done(ie_done), .tx_o(tx_o),
    .hold_empty(hold_empty), .tx_done(tx_done), .irq_hold(irq_hold), .irq_done(irq_done));

  always #10 clk = ~clk;

  typedef struct {
    logic [15:0] bits;
    int          len;
    string       tag;
  } exp_t;

  exp_t expq[$];
  int checks = 0, fails = 0, frames = 0, cyc = 0;
  int div_cnt = 0, gap = 0, gap_last = -1, pos = 0;
  bit in_frame = 0, mon_en = 1;
  logic [15:0] got;
  exp_t cur;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic exp_t make_exp(input logic [8:0] d, input string tag);
    exp_t e;
    int ones;
    int n;
    bit p;
    e.bits = '1;
    e.bits[0] = 1'b0;
    n = 1;
    ones = 0;
    for (int i = 0; i < 5 + int'(word_len); i++) begin
      e.bits[n] = d[i]; ones += int'(d[i]); n++;
    end
    if (ninth_en) begin
      e.bits[n] = d[8]; ones += int'(d[8]); n++;
    end
    if (par_en) begin
      if (par_stick) p = !par_even;
      else p = par_even ? ((ones % 2) == 1) : ((ones % 2) == 0);
      e.bits[n] = p; n++;
    end
    n += two_stop ? 2 : 1;
    e.len = n;
    e.tag = tag;
    return e;
  endfunction

  // tick generator and scoreboard monitor, both away from the active edge
  always @(negedge clk) begin
    if (baud_tick && mon_en) begin
      if (!in_frame) begin
        if (tx_o == 1'b0) begin
          got = '1;
          got[0] = 1'b0;
          pos = 1;
          gap_last = gap;
          gap = 0;
          in_frame = 1;
          if (expq.size() == 0) begin
            cur.len = 0;
            cur.tag = "R8";
            chk(0, "R8", "unexpected frame", 32'd1, 32'd0);
          end else cur = expq.pop_front();
        end else gap++;
      end else begin
        got[pos] = tx_o;
        pos++;
      end
      if (in_frame && pos >= cur.len) begin
        if (cur.len != 0)
          chk(got == cur.bits, cur.tag, "frame bits", 32'(got), 32'(cur.bits));
        frames++;
        in_frame = 0;
      end
    end
    div_cnt = (div_cnt == DIV - 1) ? 0 : div_cnt + 1;
    baud_tick = (div_cnt == DIV - 1);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n * DIV; i++) @(negedge clk);
  endtask

  task automatic raw_write(input logic [8:0] d);
    @(negedge clk);
    wr_data = d;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic send(input logic [8:0] d, input string tag);
    @(negedge clk);
    while (!hold_empty) @(negedge clk);
    expq.push_back(make_exp(d, tag));
    raw_write(d);
    while (!hold_empty) @(negedge clk);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (expq.size() != 0 || in_frame || !hold_empty) @(negedge clk);
    wait_ticks(2);
  endtask

  initial begin
    int f0;
    repeat (4) @(negedge clk);
    // R1 during reset
    chk(tx_o == 1'b1, "R1", "tx idle in reset", 32'(tx_o), 32'd1);
    chk(hold_empty == 1'b1, "R1", "hold empty in reset", 32'(hold_empty), 32'd1);
    chk(tx_done == 1'b0, "R1", "done clear in reset", 32'(tx_done), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_o == 1'b1 && hold_empty == 1'b1 && tx_done == 1'b0, "R1", "state after reset",
        {29'd0, tx_o, hold_empty, tx_done}, 32'd6);
    // R12 hold interrupt while empty
    ie_hold = 1'b1;
    @(negedge clk);
    chk(irq_hold == 1'b1, "R12", "irq_hold when empty", 32'(irq_hold), 32'd1);
    tx_enable = 1'b1;

    // R2 word lengths, high bits set to be ignored
    word_len = 2'd0; send(9'h1E5, "R2");
    word_len = 2'd1; send(9'h1AA, "R2");
    word_len = 2'd2; send(9'h0D5, "R2");
    word_len = 2'd3; send(9'h0C3, "R2");
    wait_idle();

    // R4 parity
    par_en = 1'b1; par_even = 1'b1; send(9'h0A7, "R4");
    par_even = 1'b0; send(9'h0A7, "R4");
    send(9'h000, "R4");
    par_even = 1'b1; send(9'h000, "R4");
    wait_idle();

    // R3 ninth bit with and without parity
    ninth_en = 1'b1; send(9'h13C, "R3");
    par_en = 1'b0; word_len = 2'd0; send(9'h11F, "R3");
    word_len = 2'd3; ninth_en = 1'b0;
    wait_idle();

    // R5 stick parity
    par_en = 1'b1; par_stick = 1'b1; par_even = 1'b1; send(9'h0FF, "R5");
    par_even = 1'b0; send(9'h000, "R5");
    par_stick = 1'b0; par_en = 1'b0;
    wait_idle();

    // R6 two stop bits
    two_stop = 1'b1; send(9'h05A, "R6");
    par_en = 1'b1; word_len = 2'd1; send(9'h03F, "R6");
    two_stop = 1'b0; par_en = 1'b0; word_len = 2'd3;
    wait_idle();

    // R9 back-to-back frames with no idle gap
    @(negedge clk); done_clr = 1'b1; @(negedge clk); done_clr = 1'b0;
    send(9'h011, "R9");
    send(9'h0EE, "R9");
    wait_idle();
    chk(gap_last == 0, "R9", "idle bits between frames", 32'(gap_last), 32'd0);

    // R10 completion flag and its interrupt
    chk(tx_done == 1'b1, "R10", "done after last frame", 32'(tx_done), 32'd1);
    ie_done = 1'b1;
    @(negedge clk);
    chk(irq_done == 1'b1, "R12", "irq_done when done", 32'(irq_done), 32'd1);
    done_clr = 1'b1; @(negedge clk); done_clr = 1'b0; @(negedge clk);
    chk(tx_done == 1'b0, "R10", "done cleared", 32'(tx_done), 32'd0);
    chk(irq_done == 1'b0, "R12", "irq_done cleared", 32'(irq_done), 32'd0);

    // R8 write while full is ignored
    tx_enable = 1'b0;
    wait_ticks(2);
    f0 = frames;
    expq.push_back(make_exp(9'h033, "R8"));
    raw_write(9'h033);
    raw_write(9'h0CC);
    chk(hold_empty == 1'b0, "R8", "hold full after write", 32'(hold_empty), 32'd0);
    wait_ticks(30);
    chk(frames == f0, "R11", "no frame while disabled", 32'(frames), 32'(f0));
    tx_enable = 1'b1;
    wait_idle();
    wait_ticks(20);
    chk(frames == f0 + 1, "R8", "only one frame sent", 32'(frames), 32'(f0 + 1));

    // R11 graceful disable drains shifting and held characters
    f0 = frames;
    send(9'h081, "R11");
    expq.push_back(make_exp(9'h07E, "R11"));
    raw_write(9'h07E);
    tx_enable = 1'b0;
    wait_idle();
    chk(frames == f0 + 2, "R11", "pending frames drained", 32'(frames), 32'(f0 + 2));
    raw_write(9'h0F0);
    wait_ticks(30);
    chk(frames == f0 + 2, "R11", "stopped after drain", 32'(frames), 32'(f0 + 2));
    chk(hold_empty == 1'b0 && tx_o == 1'b1, "R11", "held and idle",
        {30'd0, hold_empty, tx_o}, 32'd1);
    expq.push_back(make_exp(9'h0F0, "R11"));
    tx_enable = 1'b1;
    wait_idle();
    chk(frames == f0 + 3, "R11", "resumed after enable", 32'(frames), 32'(f0 + 3));

    // R7 break
    mon_en = 0;
    brk = 1'b1;
    repeat (3) @(negedge clk);
    chk(tx_o == 1'b0, "R7", "line low in break", 32'(tx_o), 32'd0);
    brk = 1'b0;
    @(negedge clk);
    chk(tx_o == 1'b1, "R7", "line restored", 32'(tx_o), 32'd1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule